// File: doc/BRIEF.md
# Clock Synthesizer Configuration Loader

This block keeps the working configuration of a PLL clock synthesizer: a 7-bit feedback divide value, a 2-bit post-divide code and a 3-bit test-output select. The configuration comes in over one of two paths that write the same registers. A parallel path takes the divide pins when its load strobe rises. A three-wire serial path clocks bits one at a time into a 12-bit shift register, and copies that register into the configuration when its own load strobe falls.

Every strobe, the serial clock and all data pins are brought into the system clock domain through a synchronizer chain. Edges are then found on the synchronized levels. The parallel path wins whenever both paths request a load. The serial path is shut out entirely while the parallel strobe rests low. The block also decodes the post-divide code into the divide ratio it stands for.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is high and after it is released, the outputs are fb_div_o = 7'h7F, post_code_o = 2'b11 and test_sel_o = 3'b000.
- R2: A low-to-high transition on par_load_i loads fb_div_o from par_fb_i and post_code_o from par_post_i, and it clears test_sel_o to 3'b000.
- R3: A falling par_load_i, or changes on par_fb_i/par_post_i while par_load_i stays steady, leave all outputs unchanged.
- R4: Each rising ser_clk_i shifts ser_dat_i into bit 0 of a 12-bit register, and the older bits move up. The first bit sent ends in bit 11. A falling ser_load_i loads test_sel_o from bits 11:9, post_code_o from bits 8:7 and fb_div_o from bits 6:0.
- R5: Shifting alone, and a rising ser_load_i, leave all outputs unchanged.
- R6: A falling ser_load_i while par_load_i is low has no effect on the outputs.
- R7: When a par_load_i rise and a ser_load_i fall are seen in the same cycle, the parallel pins are loaded and the serial word is discarded.
- R8: post_ratio_o is 1, 2, 4 or 8 for post_code_o equal to 0, 1, 2 or 3, and exactly one of its bits is set.
- R9: When more than 12 bits are shifted before a serial load, only the last 12 bits sent are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| par_load_i | input | 1 | Parallel load strobe; the rising edge captures the pins |
| par_fb_i | input | 7 | Parallel feedback divide value |
| par_post_i | input | 2 | Parallel post-divide code |
| ser_clk_i | input | 1 | Serial shift clock; each rising edge shifts one bit |
| ser_dat_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial load strobe; the falling edge transfers the word |
| fb_div_o | output | 7 | Latched feedback divide value |
| post_code_o | output | 2 | Latched post-divide code |
| post_ratio_o | output | 4 | Decoded post-divide ratio (1, 2, 4 or 8) |
| test_sel_o | output | 3 | Latched test-output select |

## Verification
A parallel strobe rise and a serial strobe fall can land in the same sampled cycle, and the configuration registers can take only one of them. The bench first shifts a serial word that differs in every field from the parallel pins, and raises the serial strobe while the parallel strobe is low. It then raises the parallel strobe and drops the serial strobe in the same step, so both synchronized edges reach the arbiter together. The result is judged by reading the outputs: the parallel pins with a cleared test select must appear, and no field of the serial word may appear.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int FB_W    = 7;
    localparam int POST_W  = 2;
    localparam int TSEL_W  = 3;
    localparam int WORD_W  = TSEL_W + POST_W + FB_W;
    localparam int RATIO_W = 1 << POST_W;

    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic [POST_W-1:0] post;
        logic [FB_W-1:0]   fb;
    } cfg_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PAR  = 2'd1,
        SRC_SER  = 2'd2
    } load_src_e;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.tsel = '0;
        c.post = '1;
        c.fb   = '1;
        return c;
    endfunction

    function automatic cfg_t cfg_from_pins(logic [FB_W-1:0] fb, logic [POST_W-1:0] post);
        cfg_t c;
        c.tsel = '0;
        c.post = post;
        c.fb   = fb;
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_of(logic [POST_W-1:0] code);
        logic [RATIO_W-1:0] r;
        r = '0;
        r[code] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[gi] <= '0;
                else     stg[gi] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[gi] <= '0;
                else     stg[gi] <= stg[gi-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/scfg_edge.sv
module scfg_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign rise[gi] = lvl[gi] & ~prev[gi];
        assign fall[gi] = ~lvl[gi] & prev[gi];
    end
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)       word <= '0;
        else if (step) word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/scfg_arbiter.sv
module scfg_arbiter
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              par_rise,
    input  logic              par_lvl,
    input  logic              ser_fall,
    input  logic [FB_W-1:0]   par_fb,
    input  logic [POST_W-1:0] par_post,
    input  logic [WORD_W-1:0] ser_word,
    output logic              ser_fire,
    output cfg_t              cfg
);
    load_src_e src;

    always_comb begin
        src = SRC_NONE;
        if (par_rise)                 src = SRC_PAR;
        else if (ser_fall && par_lvl) src = SRC_SER;
    end

    assign ser_fire = (src == SRC_SER);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_reset();
        end else begin
            case (src)
                SRC_PAR: cfg <= cfg_from_pins(par_fb, par_post);
                SRC_SER: cfg <= cfg_t'(ser_word);
                default: cfg <= cfg;
            endcase
        end
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               par_load_i,
    input  logic [FB_W-1:0]    par_fb_i,
    input  logic [POST_W-1:0]  par_post_i,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_load_i,
    output logic [FB_W-1:0]    fb_div_o,
    output logic [POST_W-1:0]  post_code_o,
    output logic [RATIO_W-1:0] post_ratio_o,
    output logic [TSEL_W-1:0]  test_sel_o
);
    localparam int STB_W  = 3;
    localparam int DATA_W = FB_W + POST_W + 1;
    localparam int PIN_W  = STB_W + DATA_W;

    logic [PIN_W-1:0]  pins_q;
    logic [STB_W-1:0]  stb_lvl, stb_rise, stb_fall;
    logic [FB_W-1:0]   par_fb_q;
    logic [POST_W-1:0] par_post_q;
    logic              ser_dat_q;
    logic              par_lvl, par_rise, ser_step, ser_fall, ser_fire;
    logic [WORD_W-1:0] shreg;
    cfg_t              cfg;

    scfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_load_i, ser_clk_i, par_load_i, par_fb_i, par_post_i, ser_dat_i}),
        .dout (pins_q)
    );

    assign {stb_lvl, par_fb_q, par_post_q, ser_dat_q} = pins_q;

    scfg_edge #(.W(STB_W)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (stb_lvl),
        .rise (stb_rise),
        .fall (stb_fall)
    );

    assign par_lvl  = stb_lvl[0];
    assign par_rise = stb_rise[0];
    assign ser_step = stb_rise[1];
    assign ser_fall = stb_fall[2];

    scfg_shift #(.W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .step   (ser_step),
        .bit_in (ser_dat_q),
        .word   (shreg)
    );

    scfg_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .par_rise (par_rise),
        .par_lvl  (par_lvl),
        .ser_fall (ser_fall),
        .par_fb   (par_fb_q),
        .par_post (par_post_q),
        .ser_word (shreg),
        .ser_fire (ser_fire),
        .cfg      (cfg)
    );

    assign fb_div_o     = cfg.fb;
    assign post_code_o  = cfg.post;
    assign test_sel_o   = cfg.tsel;
    assign post_ratio_o = ratio_of(cfg.post);
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
    import synth_cfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               par_rise,
    input logic               par_lvl,
    input logic               ser_fall,
    input logic               ser_fire,
    input logic [FB_W-1:0]    par_fb_q,
    input logic [POST_W-1:0]  par_post_q,
    input logic [WORD_W-1:0]  shreg,
    input logic [FB_W-1:0]    fb_div_o,
    input logic [POST_W-1:0]  post_code_o,
    input logic [RATIO_W-1:0] post_ratio_o,
    input logic [TSEL_W-1:0]  test_sel_o
);
    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fb_div_o == '1 && post_code_o == '1 && test_sel_o == '0)); // R1

    AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        par_rise |=> (fb_div_o == $past(par_fb_q) && post_code_o == $past(par_post_q) && test_sel_o == '0)); // R2

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!par_rise && !ser_fire) |=> $stable({test_sel_o, post_code_o, fb_div_o})); // R3

    AST_SER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ser_fire |=> ({test_sel_o, post_code_o, fb_div_o} == $past(shreg))); // R4

    AST_SER_GATED: assert property (@(posedge clk) disable iff (rst)
        (ser_fall && !par_lvl && !par_rise) |=> $stable({test_sel_o, post_code_o, fb_div_o})); // R6

    AST_PAR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (par_rise && ser_fall) |-> !ser_fire); // R7

    AST_RATIO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(post_ratio_o) == 1); // R8
endmodule

bind synth_cfg_loader scfg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .par_rise     (par_rise),
    .par_lvl      (par_lvl),
    .ser_fall     (ser_fall),
    .ser_fire     (ser_fire),
    .par_fb_q     (par_fb_q),
    .par_post_q   (par_post_q),
    .shreg        (shreg),
    .fb_div_o     (fb_div_o),
    .post_code_o  (post_code_o),
    .post_ratio_o (post_ratio_o),
    .test_sel_o   (test_sel_o)
);

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_load = 1'b0;
    logic [6:0] par_fb = '0;
    logic [1:0] par_post = '0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_load = 1'b0;
    logic [6:0] fb_div;
    logic [1:0] post_code;
    logic [3:0] post_ratio;
    logic [2:0] test_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    synth_cfg_loader u0 (
        .clk          (clk),
        .rst          (rst),
        .par_load_i   (par_load),
        .par_fb_i     (par_fb),
        .par_post_i   (par_post),
        .ser_clk_i    (ser_clk),
        .ser_dat_i    (ser_dat),
        .ser_load_i   (ser_load),
        .fb_div_o     (fb_div),
        .post_code_o  (post_code),
        .post_ratio_o (post_ratio),
        .test_sel_o   (test_sel)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_cfg(string req, int m, int n, int t);
        chk({req, " fb"},    int'(fb_div),     m);
        chk({req, " post"},  int'(post_code),  n);
        chk({req, " tsel"},  int'(test_sel),   t);
    endtask

    task automatic shift_bits(logic [15:0] bits, int cnt);
        for (int i = cnt - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(3);
        end
    endtask

    task automatic t_reset;
        tick(4);
        chk_cfg("R1 in reset", 7'h7F, 3, 0);
        rst = 1'b0;
        tick(4);
        chk_cfg("R1 after reset", 7'h7F, 3, 0);
        chk("R8 ratio code3", int'(post_ratio), 8);
    endtask

    task automatic t_serial_gated;
        shift_bits(16'({3'd6, 2'd1, 7'h2A}), 12);
        ser_load = 1'b1;
        tick(6);
        ser_load = 1'b0;
        tick(6);
        chk_cfg("R6 serial load with par low", 7'h7F, 3, 0);
    endtask

    task automatic t_parallel;
        par_fb = 7'h25; par_post = 2'd1;
        tick(4);
        par_load = 1'b1;
        tick(6);
        chk_cfg("R2 first par load", 7'h25, 1, 0);
        chk("R8 ratio code1", int'(post_ratio), 2);
        par_fb = 7'h11; par_post = 2'd3;
        tick(6);
        chk_cfg("R3 pins move, strobe high", 7'h25, 1, 0);
        par_load = 1'b0;
        tick(6);
        chk_cfg("R3 strobe falls", 7'h25, 1, 0);
        par_fb = 7'h5A; par_post = 2'd2;
        tick(4);
        par_load = 1'b1;
        tick(6);
        chk_cfg("R2 second par load", 7'h5A, 2, 0);
        chk("R8 ratio code2", int'(post_ratio), 4);
    endtask

    task automatic t_serial_load;
        shift_bits(16'({3'd5, 2'd0, 7'h13}), 12);
        chk_cfg("R5 after shifting only", 7'h5A, 2, 0);
        ser_load = 1'b1;
        tick(6);
        chk_cfg("R5 serial strobe rise", 7'h5A, 2, 0);
        ser_load = 1'b0;
        tick(6);
        chk_cfg("R4 serial load", 7'h13, 0, 5);
        chk("R8 ratio code0", int'(post_ratio), 1);
    endtask

    task automatic t_overshift;
        shift_bits({4'b1111, 3'd2, 2'd3, 7'h6C}, 16);
        ser_load = 1'b1;
        tick(6);
        ser_load = 1'b0;
        tick(6);
        chk_cfg("R9 last twelve bits", 7'h6C, 3, 2);
    endtask

    task automatic t_collision;
        par_load = 1'b0;
        tick(6);
        shift_bits(16'({3'd7, 2'd2, 7'h01}), 12);
        ser_load = 1'b1;
        par_fb = 7'h33; par_post = 2'd0;
        tick(6);
        chk_cfg("R6 no load while setting up", 7'h6C, 3, 2);
        par_load = 1'b1;
        ser_load = 1'b0;
        tick(8);
        chk_cfg("R7 same-cycle parallel wins", 7'h33, 0, 0);
    endtask

    initial begin
        t_reset();
        t_serial_gated();
        t_parallel();
        t_serial_load();
        t_overshift();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule